// File: doc/BRIEF.md
# Valley-Switching Turn-On Timing Controller

This block picks, once per switching cycle, the moment at which the power switch of a quasi-resonant converter is turned on again. The compensator output code sets a frequency window, given as a shortest and a longest allowed switching period. Both periods are counted in cycles of the block clock. An upstream comparator on the auxiliary winding delivers one pulse for each resonant valley. An upstream table supplies the valley number that the efficiency optimiser prefers. The block emits a one-cycle set pulse for the gate latch. Resetting the latch on peak current is done by other logic.

The window follows the compensator code along piecewise-linear curves with three breakpoints: a light-load threshold, a knee and an overload threshold. At the knee the window is widest. At and below the light-load threshold, and at and above the overload threshold, the two curves meet. Valley switching then stops and the switch runs at a fixed period. The window always has the final say over the demanded valley.

All pins are plain level or pulse signals with no handshake. The comparator pulse is taken in the cycle it is high. There is no back-pressure: a set pulse is never held off by anything downstream.

Top module: `valley_turnon_ctrl`

## Requirements
- R1: `set_pulse` is low during reset and never stays high for two consecutive cycles.
- R2: Let `vc` be the unsigned code on `vc_code`. The shortest period Pmin and the longest period Pmax are linear in `vc` on each segment. Below the knee, from VTH1 to VCMAX, both start at P_LIGHT; Pmin falls to P_FAST and Pmax falls to P_SLOW. Above the knee, from VCMAX to VTH2, Pmin moves from P_FAST to P_OVER and Pmax moves from P_SLOW to P_OVER. Each value is y0 ± floor(|y1−y0|·(vc−x0)/(x1−x0)). A code change governs decisions from the next cycle on.
- R3: The period is the number of clock cycles from one set pulse to the next. A valley pulse that is high k cycles after a set pulse and causes a turn-on gives a set pulse in the following cycle, so the period is k+1.
- R4: Valleys are numbered 1, 2, … from the last set pulse. Inside the window, a turn-on happens at the valley whose number equals `valley_demand` (binary).
- R5: A valley pulse with k+1 < Pmin causes no turn-on. It is still counted in the numbering. If the demanded valley came too early, the first valley with k+1 ≥ Pmin turns the switch on.
- R6: If no qualifying valley has come, the set pulse is forced so that the period equals Pmax exactly.
- R7: A `valley_demand` of 0 turns the switch on at the first valley the window allows.
- R8: For vc ≤ VTH1 the period is P_LIGHT, and for vc ≥ VTH2 it is P_OVER, whatever valley pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all periods are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_code | input | CW | Compensator output code, unsigned |
| valley_pulse | input | 1 | One-cycle pulse for each resonant valley |
| valley_demand | input | VW | Demanded valley number; 0 means first allowed |
| set_pulse | output | 1 | One-cycle turn-on request to the gate latch |

## Verification
A valley pulse seen k cycles after a set pulse produces the next set pulse one cycle later. A forced turn-on lands exactly Pmax cycles after the previous one. The bench therefore measures every period between set pulses, sampling at the falling edge, and compares it with the period computed from the requirement formulas. A new compensator code reaches the limit registers one cycle after it is applied. To keep changes out of the comparison, each case lets two set pulses pass after its settings change before it queues its expected periods. As a result, only periods that begin and end entirely under the new settings are compared.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic [1:0] {
    RG_LIGHT,
    RG_RISE,
    RG_FALL,
    RG_OVER
  } vt_region_e;

  // Linear interpolation from y0 toward y1 over span, truncated toward y0.
  function automatic logic [31:0] vt_interp(input logic [31:0] y0,
                                            input logic [31:0] y1,
                                            input logic [31:0] dx,
                                            input logic [31:0] span);
    if (y0 >= y1) return y0 - (((y0 - y1) * dx) / span);
    else          return y0 + (((y1 - y0) * dx) / span);
  endfunction

endpackage

// File: rtl/vt_curve.sv
module vt_curve import vt_pkg::*; #(
  parameter int CW      = 8,
  parameter int PW      = 16,
  parameter int VTH1    = 40,
  parameter int VCMAX   = 120,
  parameter int VTH2    = 200,
  parameter int Y_LIGHT = 2000,
  parameter int Y_KNEE  = 200,
  parameter int Y_OVER  = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] vc_i,
  output logic [PW-1:0] lim_o,
  output logic          flat_o
);

  localparam logic [CW-1:0] TH1_C  = CW'(VTH1);
  localparam logic [CW-1:0] KNEE_C = CW'(VCMAX);
  localparam logic [CW-1:0] TH2_C  = CW'(VTH2);
  localparam logic [31:0]   SPAN_LO = 32'(VCMAX - VTH1);
  localparam logic [31:0]   SPAN_HI = 32'(VTH2 - VCMAX);

  vt_region_e  region_d, region_q;
  logic [31:0] y_d;
  logic [31:0] vc_w;

  assign vc_w = 32'(vc_i);

  always_comb begin
    if (vc_i <= TH1_C) begin
      region_d = RG_LIGHT;
      y_d      = 32'(Y_LIGHT);
    end else if (vc_i <= KNEE_C) begin
      region_d = RG_RISE;
      y_d      = vt_interp(32'(Y_LIGHT), 32'(Y_KNEE), vc_w - 32'(VTH1), SPAN_LO);
    end else if (vc_i < TH2_C) begin
      region_d = RG_FALL;
      y_d      = vt_interp(32'(Y_KNEE), 32'(Y_OVER), vc_w - 32'(VCMAX), SPAN_HI);
    end else begin
      region_d = RG_OVER;
      y_d      = 32'(Y_OVER);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region_q <= RG_LIGHT;
      lim_o    <= PW'(Y_LIGHT);
    end else begin
      region_q <= region_d;
      lim_o    <= y_d[PW-1:0];
    end
  end

  assign flat_o = (region_q == RG_LIGHT) || (region_q == RG_OVER);

endmodule

// File: rtl/vt_period_timer.sv
module vt_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] lim_min,
  input  logic [PW-1:0] lim_max,
  output logic          win_open,
  output logic          expire
);

  logic [PW-1:0] cnt_q;
  logic [PW:0]   period_if_now;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= PW'(1);
    else if (cnt_q != '1)    cnt_q <= cnt_q + PW'(1);
  end

  // A turn-on decided in this cycle yields a period of cnt+1.
  assign period_if_now = {1'b0, cnt_q} + (PW+1)'(1);
  assign win_open      = period_if_now >= {1'b0, lim_min};
  assign expire        = period_if_now >= {1'b0, lim_max};

endmodule

// File: rtl/vt_valley_index.sv
module vt_valley_index #(
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          valley_i,
  input  logic [VW-1:0] demand_i,
  output logic          reached_o
);

  logic [VW-1:0] idx_q;
  logic [VW:0]   this_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)                        idx_q <= '0;
    else if (restart)                  idx_q <= '0;
    else if (valley_i && idx_q != '1)  idx_q <= idx_q + VW'(1);
  end

  assign this_idx  = {1'b0, idx_q} + (VW+1)'(1);
  assign reached_o = valley_i && (this_idx >= {1'b0, demand_i});

endmodule

// File: rtl/valley_turnon_ctrl.sv
module valley_turnon_ctrl #(
  parameter int CW      = 8,
  parameter int VW      = 4,
  parameter int PW      = 16,
  parameter int VTH1    = 40,
  parameter int VCMAX   = 120,
  parameter int VTH2    = 200,
  parameter int P_LIGHT = 2000,
  parameter int P_SLOW  = 800,
  parameter int P_FAST  = 200,
  parameter int P_OVER  = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] vc_code,
  input  logic          valley_pulse,
  input  logic [VW-1:0] valley_demand,
  output logic          set_pulse
);

  localparam int NCURVE = 2;

  logic [NCURVE-1:0][PW-1:0] lim;
  logic [NCURVE-1:0]         flat;
  logic [PW-1:0]             lim_min;
  logic [PW-1:0]             lim_max;
  logic                      collapse;
  logic                      win_open;
  logic                      expire;
  logic                      valley_hit;
  logic                      fire;
  logic                      set_q;

  // Curve 0 bounds the period from below, curve 1 from above.
  for (genvar g = 0; g < NCURVE; g++) begin : g_curve
    localparam int KNEE = (g == 0) ? P_FAST : P_SLOW;
    vt_curve #(
      .CW(CW), .PW(PW), .VTH1(VTH1), .VCMAX(VCMAX), .VTH2(VTH2),
      .Y_LIGHT(P_LIGHT), .Y_KNEE(KNEE), .Y_OVER(P_OVER)
    ) u_curve (
      .clk   (clk),
      .rst_n (rst_n),
      .vc_i  (vc_code),
      .lim_o (lim[g]),
      .flat_o(flat[g])
    );
  end

  assign lim_min  = lim[0];
  assign lim_max  = lim[1];
  assign collapse = |flat;

  vt_period_timer #(.PW(PW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (set_q),
    .lim_min (lim_min),
    .lim_max (lim_max),
    .win_open(win_open),
    .expire  (expire)
  );

  vt_valley_index #(.VW(VW)) u_vidx (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (set_q),
    .valley_i (valley_pulse),
    .demand_i (valley_demand),
    .reached_o(valley_hit)
  );

  // The window has the last word: a forced turn-on at the long limit,
  // a valley turn-on only once the short limit has passed and only
  // while the window is open.
  assign fire = !set_q && (expire || (valley_hit && win_open && !collapse));

  always_ff @(posedge clk) begin
    if (!rst_n) set_q <= 1'b0;
    else        set_q <= fire;
  end

  assign set_pulse = set_q;

endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          set_pulse,
  input logic          valley_pulse,
  input logic [PW-1:0] lim_min,
  input logic [PW-1:0] lim_max,
  input logic          collapse
);

  logic [PW:0] gap_q;
  logic [PW:0] gap_nx;

  always_ff @(posedge clk) begin
    if (!rst_n)            gap_q <= '0;
    else if (set_pulse)    gap_q <= (PW+1)'(1);
    else if (gap_q != '1)  gap_q <= gap_q + (PW+1)'(1);
  end

  assign gap_nx = gap_q + (PW+1)'(1);

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> !set_pulse);

  assert_min_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> (gap_q >= {1'b0, $past(lim_min)}));

  assert_early_valley_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_pulse && !set_pulse && (gap_nx < {1'b0, lim_min})) |=> !set_pulse);

  assert_max_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pulse && (gap_nx >= {1'b0, lim_max})) |=> set_pulse);

  assert_collapse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (collapse && valley_pulse && !set_pulse && (gap_nx < {1'b0, lim_max})) |=> !set_pulse);

endmodule

bind valley_turnon_ctrl vt_checker #(.PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .set_pulse   (set_q),
  .valley_pulse(valley_pulse),
  .lim_min     (lim_min),
  .lim_max     (lim_max),
  .collapse    (collapse)
);

// File: tb/tb_valley_turnon_ctrl.sv
module tb_valley_turnon_ctrl;

  localparam int CW = 8, VW = 4, PW = 16;
  localparam int VTH1 = 40, VCMAX = 120, VTH2 = 200;
  localparam int P_LIGHT = 2000, P_SLOW = 800, P_FAST = 200, P_OVER = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] vc_code = '0;
  logic          valley_pulse = 1'b0;
  logic [VW-1:0] valley_demand = '0;
  logic          set_pulse;

  valley_turnon_ctrl #(
    .CW(CW), .VW(VW), .PW(PW), .VTH1(VTH1), .VCMAX(VCMAX), .VTH2(VTH2),
    .P_LIGHT(P_LIGHT), .P_SLOW(P_SLOW), .P_FAST(P_FAST), .P_OVER(P_OVER)
  ) dut (
    .clk(clk), .rst_n(rst_n), .vc_code(vc_code), .valley_pulse(valley_pulse),
    .valley_demand(valley_demand), .set_pulse(set_pulse)
  );

  always #4 clk = ~clk;

  typedef struct { int period; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int npulse = 0;
  bit done = 1'b0;

  // valley generator settings
  bit gen_en = 1'b0;
  int gen_k0 = 1, gen_kp = 0;

  function automatic int interp(int y0, int y1, int dx, int span);
    if (y0 >= y1) return y0 - ((y0 - y1) * dx) / span;
    else          return y0 + ((y1 - y0) * dx) / span;
  endfunction

  function automatic int expected_period(int vc, int dem, bit en, int k0, int kp);
    int pmin, pmax;
    bit flat;
    flat = 1'b0;
    if (vc <= VTH1) begin
      pmin = P_LIGHT; pmax = P_LIGHT; flat = 1'b1;
    end else if (vc <= VCMAX) begin
      pmin = interp(P_LIGHT, P_FAST, vc - VTH1, VCMAX - VTH1);
      pmax = interp(P_LIGHT, P_SLOW, vc - VTH1, VCMAX - VTH1);
    end else if (vc < VTH2) begin
      pmin = interp(P_FAST, P_OVER, vc - VCMAX, VTH2 - VCMAX);
      pmax = interp(P_SLOW, P_OVER, vc - VCMAX, VTH2 - VCMAX);
    end else begin
      pmin = P_OVER; pmax = P_OVER; flat = 1'b1;
    end
    if (flat || !en) return pmax;
    for (int j = 0; j < 100000; j++) begin
      int k;
      k = k0 + j * kp;
      if (k + 1 >= pmax) return pmax;
      if ((j + 1) >= dem && k + 1 >= pmin) return k + 1;
      if (kp == 0) return pmax;
    end
    return pmax;
  endfunction

  // Valley generator: k counts cycles since the last set pulse.
  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      if (set_pulse) k = 0;
      else k++;
      valley_pulse = gen_en && (k >= gen_k0) &&
                     ((gen_kp == 0) ? (k == gen_k0) : (((k - gen_k0) % gen_kp) == 0));
    end
  end

  // Monitor: measures periods between set pulses and compares with the queue.
  initial begin
    int cyc, last;
    bit have_last, prev_set;
    cyc = 0; last = 0; have_last = 1'b0; prev_set = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && set_pulse) begin
        if (have_last && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (prev_set) begin
            errors++;
            $display("FAIL R1 set pulse width: actual 2+ cycles expected 1");
          end else if (cyc - last != e.period) begin
            errors++;
            $display("FAIL %s period: actual %0d expected %0d", e.tag, cyc - last, e.period);
          end
        end
        last = cyc;
        have_last = 1'b1;
        npulse++;
      end
      prev_set = set_pulse;
    end
  end

  task automatic run_case(int vc, int dem, bit en, int k0, int kp, string tag);
    int target;
    exp_t e;
    @(negedge clk);
    vc_code = CW'(vc);
    valley_demand = VW'(dem);
    gen_en = en; gen_k0 = k0; gen_kp = kp;
    target = npulse + 2;
    wait (npulse >= target);
    e.period = expected_period(vc, dem, en, k0, kp);
    e.tag = tag;
    q.push_back(e);
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checks++;
      if (set_pulse !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset state: actual %b expected 0", set_pulse);
      end
    end
    rst_n = 1'b1;

    run_case(120, 6, 1'b1, 60, 40, "R4");    // demanded valley inside window
    run_case(120, 3, 1'b1, 60, 40, "R5");    // demanded valley too early
    run_case(120, 1, 1'b1, 10, 40, "R5");    // first valley after short limit
    run_case(120, 0, 1'b1, 250, 40, "R7");   // demand zero
    run_case(120, 2, 1'b0, 60, 40, "R6");    // no valleys at all
    run_case(120, 15, 1'b1, 60, 60, "R6");   // demanded valley beyond long limit
    run_case(80, 2, 1'b1, 60, 100, "R2");    // interpolated lower segment
    run_case(41, 1, 1'b1, 1980, 0, "R2");    // just above light threshold
    run_case(160, 1, 1'b1, 299, 0, "R3");    // valley exactly at short limit
    run_case(160, 1, 1'b1, 298, 0, "R5");    // valley one cycle too early
    run_case(20, 1, 1'b1, 100, 50, "R8");    // light load, valleys ignored
    run_case(40, 1, 1'b1, 100, 50, "R8");    // light threshold itself
    run_case(220, 1, 1'b1, 100, 50, "R8");   // overload, valleys ignored
    run_case(200, 0, 1'b1, 50, 30, "R8");    // overload threshold itself

    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 190000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule